// File: doc/BRIEF.md
# Packed Parallel Sample Input Bank

This block is a bank of per-channel sample registers that sits between a processor or DMA write port and a digital filter. Each 32-bit word written to a channel carries two 16-bit signed half-words. A per-channel packing mode decides which half-words are taken and how many filter samples one write produces. In standard packing a word yields one sample. In interleaved packing it yields two samples, taken in sequence. In paired packing the even channel keeps the lower half-word and passes the upper half-word to its odd neighbour.

A per-channel 2-bit source field decides two things: whether the register drives the filter, and whether the bus may write to it. On the filter side each channel has its own valid/ready handshake. Each channel also provides a one-cycle indication that new data has arrived and a sticky overrun flag. The overrun flag is set when a write replaces samples that the filter has not yet consumed.

Top module: `pps_bank`

## Requirements
- R1: After a synchronous reset, no channel is valid, every new-sample and overrun output is 0, and all stored data is 0.
- R2: The source field of channel c sits at `src_sel[2c+1:2c]`. Value 2 means the bus may write and the register feeds the filter. Value 1 means the register feeds the filter but bus writes are ignored. Value 0 means the register neither feeds the filter nor accepts writes. `smp_valid[c]` is never high unless the field is 1 or 2, and pending samples stay held while the field is 0.
- R3: With packing mode 0 (at `pack_mode[2c+1:2c]`), a write with half-word enable bit 0 set stores `wr_data[15:0]` as the only sample. The upper half-word is ignored.
- R4: With packing mode 1, the enabled lower half-word is delivered first and the enabled upper half-word (`wr_data[31:16]`) second, both on the same channel. A write that enables only the upper half yields one sample, which is the upper half-word.
- R5: With packing mode 2 on an even channel, the lower half-word becomes that channel's sample and the upper half-word becomes the lower sample of channel c+1. For a write enabling both halves, `new_smp` rises for both channels in the same cycle.
- R6: With packing mode 2, a direct bus write to an odd channel changes nothing on that channel.
- R7: A write whose enabled half-words are all protected in the current mode raises no `new_smp` and adds no pending sample.
- R8: Each write sets the channel's pending count (0 to 2) to the number of samples it yields. Each cycle with both `smp_valid[c]` and `smp_ready[c]` high consumes exactly one sample.
- R9: If a write yields samples while samples from an earlier write are still unconsumed, the channel's overrun flag rises. The new samples replace the old ones. The flag stays set until a cycle with `ovr_clr[c]` high and no new overrun.
- R10: `new_smp[c]` is high for exactly the cycle that follows the clock edge at which a sample-producing write was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_ch | input | CH_W | Target channel of the write |
| wr_hmask | input | 2 | Half-word enables: bit 0 lower, bit 1 upper |
| wr_data | input | 2*SMP_W | Write word: lower sample in low half, upper sample in high half |
| src_sel | input | 2*NUM_CH | Per-channel source field (0 off, 1 feed only, 2 feed and bus-writable) |
| pack_mode | input | 2*NUM_CH | Per-channel packing mode (0 standard, 1 interleaved, 2 paired, 3 rejects writes) |
| ovr_clr | input | NUM_CH | Per-channel overrun clear strobe |
| smp_ready | input | NUM_CH | Filter accepts the offered sample |
| smp_valid | output | NUM_CH | A sample is offered |
| smp_data | output | NUM_CH*SMP_W | Offered signed sample of each channel |
| new_smp | output | NUM_CH | One-cycle new-data pulse |
| ovr | output | NUM_CH | Sticky overrun flag |

## Verification
The bench builds the bank with four channels of 16-bit samples. This gives two even/odd pairs, so one pair can run in paired mode while the other runs standard or interleaved. Such a layout shows that the upper half-word reaches only its own odd partner and that unrelated channels remain quiet. Overrun and same-cycle drain behaviour are exercised on the interleaved channel, because it is the only mode that holds two pending samples.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    PK_STD  = 2'd0,
    PK_ILV  = 2'd1,
    PK_PAIR = 2'd2,
    PK_RSV  = 2'd3
  } pack_e;

  localparam logic [1:0] SRC_OFF  = 2'd0;
  localparam logic [1:0] SRC_FEED = 2'd1;
  localparam logic [1:0] SRC_BUS  = 2'd2;
endpackage

// File: rtl/pps_wr_decode.sv
module pps_wr_decode
  import pps_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                  wr_en,
  input  logic [CH_W-1:0]       wr_ch,
  input  logic [1:0]            wr_hmask,
  input  logic [2*NUM_CH-1:0]   src_sel,
  input  logic [2*NUM_CH-1:0]   pack_mode,
  output logic [NUM_CH-1:0]     lo_we,
  output logic [NUM_CH-1:0]     lo_cp,
  output logic [NUM_CH-1:0]     hi_we,
  output logic [NUM_CH-1:0]     start_hi,
  output logic [2*NUM_CH-1:0]   n_new
);
  logic [NUM_CH-1:0] cp_out;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic  hit;
    pack_e mode;
    logic  cp_in;

    assign mode = pack_e'(pack_mode[2*c +: 2]);
    assign hit  = wr_en && (wr_ch == CH_W'(c)) && (src_sel[2*c +: 2] == SRC_BUS);

    if (c % 2 == 0) begin : g_even
      assign cp_out[c] = hit && (mode == PK_PAIR) && wr_hmask[1];
      assign cp_in     = 1'b0;
    end else begin : g_odd
      assign cp_out[c] = 1'b0;
      assign cp_in     = cp_out[c-1];
    end

    always_comb begin
      lo_we[c]       = 1'b0;
      lo_cp[c]       = 1'b0;
      hi_we[c]       = 1'b0;
      start_hi[c]    = 1'b0;
      n_new[2*c +: 2] = 2'd0;
      if (cp_in) begin
        lo_we[c]        = 1'b1;
        lo_cp[c]        = 1'b1;
        n_new[2*c +: 2] = 2'd1;
      end else if (hit) begin
        unique case (mode)
          PK_STD: begin
            lo_we[c]        = wr_hmask[0];
            n_new[2*c +: 2] = {1'b0, wr_hmask[0]};
          end
          PK_ILV: begin
            lo_we[c]        = wr_hmask[0];
            hi_we[c]        = wr_hmask[1];
            start_hi[c]     = !wr_hmask[0];
            n_new[2*c +: 2] = 2'(wr_hmask[0]) + 2'(wr_hmask[1]);
          end
          PK_PAIR: begin
            if (c % 2 == 0) begin
              lo_we[c]        = wr_hmask[0];
              n_new[2*c +: 2] = {1'b0, wr_hmask[0]};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pps_chan.sv
module pps_chan #(
  parameter int SMP_W = 16,
  localparam int WORD_W = 2 * SMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              lo_cp,
  input  logic              hi_we,
  input  logic              start_hi,
  input  logic [1:0]        n_new,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              feed,
  input  logic              ready,
  input  logic              ovr_clr,
  output logic              valid,
  output logic [SMP_W-1:0]  data,
  output logic              new_smp,
  output logic              ovr
);
  logic [SMP_W-1:0] lo_q, hi_q;
  logic [1:0]       cnt_q;
  logic             rd_hi_q;
  logic             take;
  logic [1:0]       left;

  assign valid = (cnt_q != 2'd0) && feed;
  assign data  = rd_hi_q ? hi_q : lo_q;
  assign take  = valid && ready;
  assign left  = cnt_q - 2'(take);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      cnt_q   <= 2'd0;
      rd_hi_q <= 1'b0;
      new_smp <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      new_smp <= (n_new != 2'd0);
      if (lo_we) lo_q <= lo_cp ? wr_word[WORD_W-1:SMP_W] : wr_word[SMP_W-1:0];
      if (hi_we) hi_q <= wr_word[WORD_W-1:SMP_W];
      if (n_new != 2'd0) begin
        cnt_q   <= n_new;
        rd_hi_q <= start_hi;
      end else if (take) begin
        cnt_q   <= left;
        rd_hi_q <= 1'b1;
      end
      if ((n_new != 2'd0) && (left != 2'd0)) ovr <= 1'b1;
      else if (ovr_clr)                      ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/pps_bank.sv
module pps_bank
  import pps_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SMP_W  = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int WORD_W = 2 * SMP_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic [1:0]              wr_hmask,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [2*NUM_CH-1:0]     src_sel,
  input  logic [2*NUM_CH-1:0]     pack_mode,
  input  logic [NUM_CH-1:0]       ovr_clr,
  input  logic [NUM_CH-1:0]       smp_ready,
  output logic [NUM_CH-1:0]       smp_valid,
  output logic [NUM_CH*SMP_W-1:0] smp_data,
  output logic [NUM_CH-1:0]       new_smp,
  output logic [NUM_CH-1:0]       ovr
);
  logic [NUM_CH-1:0]   lo_we, lo_cp, hi_we, start_hi;
  logic [2*NUM_CH-1:0] n_new;

  pps_wr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_en     (wr_en),
    .wr_ch     (wr_ch),
    .wr_hmask  (wr_hmask),
    .src_sel   (src_sel),
    .pack_mode (pack_mode),
    .lo_we     (lo_we),
    .lo_cp     (lo_cp),
    .hi_we     (hi_we),
    .start_hi  (start_hi),
    .n_new     (n_new)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic feed;
    assign feed = (src_sel[2*c +: 2] == SRC_FEED) || (src_sel[2*c +: 2] == SRC_BUS);

    pps_chan #(.SMP_W(SMP_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .lo_we    (lo_we[c]),
      .lo_cp    (lo_cp[c]),
      .hi_we    (hi_we[c]),
      .start_hi (start_hi[c]),
      .n_new    (n_new[2*c +: 2]),
      .wr_word  (wr_data),
      .feed     (feed),
      .ready    (smp_ready[c]),
      .ovr_clr  (ovr_clr[c]),
      .valid    (smp_valid[c]),
      .data     (smp_data[c*SMP_W +: SMP_W]),
      .new_smp  (new_smp[c]),
      .ovr      (ovr[c])
    );
  end
endmodule

// File: rtl/pps_bank_chk.sv
module pps_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int SMP_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [CH_W-1:0]       wr_ch,
  input logic [1:0]            wr_hmask,
  input logic [2*NUM_CH-1:0]   src_sel,
  input logic [2*NUM_CH-1:0]   pack_mode,
  input logic [NUM_CH-1:0]     ovr_clr,
  input logic [NUM_CH-1:0]     smp_valid,
  input logic [NUM_CH-1:0]     new_smp,
  input logic [NUM_CH-1:0]     ovr
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (smp_valid == '0 && new_smp == '0 && ovr == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_valid_feed_R2: assert property (@(posedge clk) disable iff (rst)
      smp_valid[c] |-> (src_sel[2*c +: 2] == 2'd1 || src_sel[2*c +: 2] == 2'd2));

    assert_locked_write_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_ch == CH_W'(c) && src_sel[2*c +: 2] != 2'd2) |=> !new_smp[c]);

    assert_new_needs_write_R10: assert property (@(posedge clk) disable iff (rst)
      new_smp[c] |-> $past(wr_en));

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (ovr[c] && !ovr_clr[c]) |=> ovr[c]);

    if (c % 2 == 0 && c + 1 < NUM_CH) begin : g_even
      assert_pair_both_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ch == CH_W'(c) && src_sel[2*c +: 2] == 2'd2 &&
         pack_mode[2*c +: 2] == 2'd2 && wr_hmask == 2'b11)
        |=> (new_smp[c] && new_smp[c+1]));
    end else if (c % 2 == 1) begin : g_odd
      assert_odd_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ch == CH_W'(c) && pack_mode[2*c +: 2] == 2'd2) |=> !new_smp[c]);
    end
  end
endmodule

bind pps_bank pps_bank_chk #(.NUM_CH(NUM_CH), .SMP_W(SMP_W)) u_chk (.*);

// File: tb/test_pps_bank.sv
module test_pps_bank;
  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam int CW  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [CW-1:0]     wr_ch = '0;
  logic [1:0]        wr_hmask = '0;
  logic [2*SW-1:0]   wr_data = '0;
  logic [2*NCH-1:0]  src_sel = '0;
  logic [2*NCH-1:0]  pack_mode = '0;
  logic [NCH-1:0]    ovr_clr = '0;
  logic [NCH-1:0]    smp_ready = '0;
  logic [NCH-1:0]    smp_valid;
  logic [NCH*SW-1:0] smp_data;
  logic [NCH-1:0]    new_smp;
  logic [NCH-1:0]    ovr;

  pps_bank #(.NUM_CH(NCH), .SMP_W(SW)) i_pps_bank (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [SW-1:0] exp_q [NCH][$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a handshake is about to complete
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        if (smp_valid[c] && smp_ready[c]) begin
          n_chk++;
          if (exp_q[c].size() == 0) begin
            n_fail++;
            $display("FAIL R8 ch%0d: actual %0h expected none", c, smp_data[c*SW +: SW]);
          end else begin
            logic [SW-1:0] e;
            e = exp_q[c].pop_front();
            if (smp_data[c*SW +: SW] !== e) begin
              n_fail++;
              $display("FAIL R8 ch%0d sample: actual %0h expected %0h", c, smp_data[c*SW +: SW], e);
            end
          end
        end
      end
    end
  end

  task automatic cfg(int ch, logic [1:0] sel, logic [1:0] mode);
    src_sel[2*ch +: 2]   = sel;
    pack_mode[2*ch +: 2] = mode;
  endtask

  task automatic wr(int ch, logic [1:0] hm, logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_ch = CW'(ch); wr_hmask = hm; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0; wr_hmask = 2'b00;
    @(negedge clk);
  endtask

  task automatic take(int ch);
    @(posedge clk); #2;
    smp_ready[ch] = 1'b1;
    @(posedge clk); #2;
    smp_ready[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", 32'(smp_valid), 0);
    chk("R1 new", 32'(new_smp), 0);
    chk("R1 ovr", 32'(ovr), 0);
    chk("R1 data", smp_data[31:0], 0);

    // R3: standard mode, lower is the one sample
    cfg(0, 2'd2, 2'd0);
    wr(0, 2'b11, 32'hBEEF_1234);
    exp_q[0].push_back(16'h1234);
    chk("R10 new ch0", 32'(new_smp), 32'h1);
    chk("R3 valid", 32'(smp_valid[0]), 1);
    take(0);
    chk("R3 upper ignored", 32'(smp_valid[0]), 0);

    // R7: protected-only write
    wr(0, 2'b10, 32'h7777_0000);
    chk("R7 new", 32'(new_smp), 0);
    chk("R7 valid", 32'(smp_valid[0]), 0);

    // R4: interleaved, lower then upper
    cfg(1, 2'd2, 2'd1);
    wr(1, 2'b11, 32'h2222_1111);
    exp_q[1].push_back(16'h1111);
    exp_q[1].push_back(16'h2222);
    chk("R4 new", 32'(new_smp), 32'h2);
    take(1);
    chk("R8 one left", 32'(smp_valid[1]), 1);
    take(1);
    chk("R4 drained", 32'(smp_valid[1]), 0);
    wr(1, 2'b10, 32'h3333_0000);
    exp_q[1].push_back(16'h3333);
    take(1);
    chk("R4 upper only", 32'(smp_valid[1]), 0);

    // R5: paired mode on ch2 -> ch3
    cfg(2, 2'd2, 2'd2);
    cfg(3, 2'd1, 2'd2);
    wr(2, 2'b11, 32'h5555_4444);
    exp_q[2].push_back(16'h4444);
    exp_q[3].push_back(16'h5555);
    chk("R5 both new", 32'(new_smp), 32'hC);
    take(2);
    take(3);
    chk("R5 drained", 32'(smp_valid), 0);

    // R6: direct write to odd paired channel
    cfg(3, 2'd2, 2'd2);
    wr(3, 2'b11, 32'h6666_6666);
    chk("R6 new", 32'(new_smp), 0);
    chk("R6 valid", 32'(smp_valid[3]), 0);

    // R2: source field gating
    cfg(0, 2'd1, 2'd0);
    wr(0, 2'b01, 32'h0000_0099);
    chk("R2 feed-only write", 32'(new_smp), 0);
    chk("R2 feed-only valid", 32'(smp_valid[0]), 0);
    cfg(0, 2'd2, 2'd0);
    wr(0, 2'b01, 32'h0000_0077);
    exp_q[0].push_back(16'h0077);
    cfg(0, 2'd0, 2'd0);
    #1;
    chk("R2 off valid", 32'(smp_valid[0]), 0);
    cfg(0, 2'd1, 2'd0);
    #1;
    chk("R2 held", 32'(smp_valid[0]), 1);
    take(0);

    // R9: overrun on interleaved channel
    wr(1, 2'b11, 32'hA2A2_A1A1);
    chk("R9 no ovr yet", 32'(ovr[1]), 0);
    wr(1, 2'b11, 32'hB2B2_B1B1);
    exp_q[1].delete();
    exp_q[1].push_back(16'hB1B1);
    exp_q[1].push_back(16'hB2B2);
    chk("R9 set", 32'(ovr[1]), 1);
    repeat (3) @(negedge clk);
    chk("R9 sticky", 32'(ovr[1]), 1);
    @(posedge clk); #2 ovr_clr[1] = 1'b1;
    @(posedge clk); #2 ovr_clr[1] = 1'b0;
    @(negedge clk);
    chk("R9 cleared", 32'(ovr[1]), 0);
    take(1);
    take(1);
    chk("R8 empty", 32'(smp_valid[1]), 0);

    for (int c = 0; c < NCH; c++) chk("R8 queue left", 32'(exp_q[c].size()), 0);
    finish_run();
  end
endmodule